// File: doc/BRIEF.md
# Coalescing Interrupt Source Bank

This block holds a bank of interrupt sources. Each source keeps a two-bit state with a pending flag P and a retrigger flag Q. The state ensures that a source has at most one event outstanding toward the delivery queue. A rising request on a source's trigger line produces a one-cycle notify pulse only if the source is idle. If the source is already pending, the request is folded into Q. When software acknowledges the event (EOI), a folded request is re-issued as a fresh notify.

Software reaches each source through its own 4 KiB page in a memory-mapped window, and the page index comes from the address bits above the page offset. Within a page, the offset of a read chooses the side effect: EOI, a plain query, or forcing one of the four state values. Every such read returns the state as it stood just before its own effect. On sources built with that capability, a write to a dedicated offset also performs an EOI.

Top module: `pq_source_bank`

## Requirements
- R1: After reset every source's state is 00, no notify bit is set, and `rd_valid_o` is low.
- R2: A trigger on a source in state 00 moves it to 10 and pulses that source's `notify_o` bit for one cycle.
- R3: A trigger on a source whose P bit is set produces no notify and sets Q, giving 11. Further triggers leave it at 11.
- R4: State 01 is the off state. Triggers do not change it and raise no notify, and an EOI leaves it at 01.
- R5: A read at page offset 0x000 is an EOI and returns the previous state. From 10 or 00 the state becomes 00. From 11 it becomes 10 and the source pulses `notify_o` again.
- R6: A read at page offset 0x800 returns the current state and leaves it unchanged.
- R7: Reads at page offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11, each returning the previous state. In all returned data, P is bit 1 (0x2), Q is bit 0 (0x1), and every other bit is zero.
- R8: A write at page offset 0x400 performs an EOI only on sources whose bit in `STORE_EOI_MASK` is set. On other sources it has no effect, and writes never produce read data.
- R9: The source index is the address above the 12-bit page offset. A read whose index is out of range, or whose offset is not one listed here, returns zero and changes no state. It still raises `rd_valid_o`.
- R10: When a trigger and an access hit the same source in one cycle, the trigger is applied first. The access then acts on, and returns, the post-trigger state.
- R11: Read data and `rd_valid_o` appear in the cycle after the access is presented, and so does any notify caused by a trigger or EOI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | NUM_SRC | Per-source trigger request, one cycle per event |
| acc_valid_i | input | 1 | Register-window access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Access byte address: source index above the page offset |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | DATA_W | Previous state of the addressed source (P bit 1, Q bit 0) |
| notify_o | output | NUM_SRC | Per-source queue-notify pulse |

## Verification
The bench builds the block with its defaults: eight sources, a 16-bit address and a store-EOI mask of 0x55. The 4-bit index field therefore reaches indices 8 to 15, which exercises the out-of-range path. The alternating mask provides one source that honours the store EOI and a neighbour that must ignore it. Every state and transition in the two-bit machine is driven from the trigger side and from the register window, including the cycle where both hit one source.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_EOI,
        OP_GET,
        OP_SET
    } pq_op_e;

    localparam int          OFS_W         = 12;
    localparam logic [11:0] OFS_LOAD_EOI  = 12'h000;
    localparam logic [11:0] OFS_STORE_EOI = 12'h400;
    localparam logic [11:0] OFS_GET       = 12'h800;
    localparam int          OFS_SET_BASE  = 'hC00;
    localparam int          OFS_SET_STEP  = 'h100;
    localparam int          NUM_SET_OFS   = 4;

    localparam pq_t PQ_IDLE = '{p: 1'b0, q: 1'b0};
    localparam pq_t PQ_OFF  = '{p: 1'b0, q: 1'b1};
    localparam pq_t PQ_PEND = '{p: 1'b1, q: 1'b0};
    localparam pq_t PQ_BOTH = '{p: 1'b1, q: 1'b1};

    function automatic pq_t pq_trig_next(pq_t s);
        pq_t n;
        case (s)
            PQ_IDLE: n = PQ_PEND;
            PQ_PEND: n = PQ_BOTH;
            default: n = s;
        endcase
        return n;
    endfunction

    function automatic logic pq_trig_fires(pq_t s);
        return s == PQ_IDLE;
    endfunction

    function automatic pq_t pq_eoi_next(pq_t s);
        pq_t n;
        case (s)
            PQ_BOTH: n = PQ_PEND;
            PQ_OFF:  n = PQ_OFF;
            default: n = PQ_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic pq_eoi_fires(pq_t s);
        return s == PQ_BOTH;
    endfunction

endpackage

// File: rtl/pq_decode.sv
module pq_decode
    import pq_pkg::*;
#(
    parameter int                 NUM_SRC        = 8,
    parameter int                 ADDR_W         = 16,
    parameter int                 PAGE_BITS      = 12,
    parameter logic [NUM_SRC-1:0] STORE_EOI_MASK = '1
) (
    input  logic               acc_valid_i,
    input  logic               acc_write_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    output logic [NUM_SRC-1:0] sel_o,
    output pq_op_e             op_o,
    output pq_t                set_val_o,
    output logic               is_read_o
);
    localparam int IDX_W = ADDR_W - PAGE_BITS;

    logic [IDX_W-1:0]     idx;
    logic [PAGE_BITS-1:0] ofs;
    logic                 store_path;

    assign idx = acc_addr_i[ADDR_W-1:PAGE_BITS];
    assign ofs = acc_addr_i[PAGE_BITS-1:0];

    always_comb begin
        op_o       = OP_NONE;
        set_val_o  = PQ_IDLE;
        store_path = 1'b0;
        is_read_o  = acc_valid_i && !acc_write_i;
        if (acc_valid_i) begin
            if (acc_write_i) begin
                if (ofs == PAGE_BITS'(OFS_STORE_EOI)) begin
                    op_o       = OP_EOI;
                    store_path = 1'b1;
                end
            end else if (ofs == PAGE_BITS'(OFS_LOAD_EOI)) begin
                op_o = OP_EOI;
            end else if (ofs == PAGE_BITS'(OFS_GET)) begin
                op_o = OP_GET;
            end else begin
                for (int k = 0; k < NUM_SET_OFS; k++) begin
                    if (ofs == PAGE_BITS'(OFS_SET_BASE + k * OFS_SET_STEP)) begin
                        op_o      = OP_SET;
                        set_val_o = pq_t'(k[1:0]);
                    end
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
        assign sel_o[i] = (op_o != OP_NONE) && (idx == IDX_W'(i))
                          && (!store_path || STORE_EOI_MASK[i]);
    end

endmodule

// File: rtl/pq_cell.sv
module pq_cell
    import pq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   trig_i,
    input  logic   sel_i,
    input  pq_op_e op_i,
    input  pq_t    set_val_i,
    output pq_t    view_o,
    output logic   notify_o
);
    pq_t  state_q;
    pq_t  after_trig;
    pq_t  state_d;
    logic fire;

    always_comb begin
        after_trig = trig_i ? pq_trig_next(state_q) : state_q;
        fire       = trig_i && pq_trig_fires(state_q);
        state_d    = after_trig;
        if (sel_i) begin
            case (op_i)
                OP_EOI: begin
                    state_d = pq_eoi_next(after_trig);
                    fire    = fire || pq_eoi_fires(after_trig);
                end
                OP_SET:  state_d = set_val_i;
                default: state_d = after_trig;
            endcase
        end
    end

    assign view_o = after_trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PQ_IDLE;
            notify_o <= 1'b0;
        end else begin
            state_q  <= state_d;
            notify_o <= fire;
        end
    end

    p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == PQ_OFF && !(sel_i && op_i == OP_SET)) |=> (!notify_o && state_q == PQ_OFF));

    p_retrig_sets_q_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q.p && trig_i && !sel_i) |=> (state_q == PQ_BOTH && !notify_o));

    p_first_trig_fires_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PQ_IDLE && trig_i && !sel_i) |=> (notify_o && state_q == PQ_PEND));

    p_get_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_i && op_i == OP_GET && !trig_i) |=> $stable(state_q));

    p_set_value_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_i && op_i == OP_SET) |=> state_q == $past(set_val_i));

    p_eoi_refire_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_i && op_i == OP_EOI && !trig_i && state_q == PQ_BOTH) |=> (notify_o && state_q == PQ_PEND));

endmodule

// File: rtl/pq_source_bank.sv
module pq_source_bank
    import pq_pkg::*;
#(
    parameter int                 NUM_SRC        = 8,
    parameter int                 ADDR_W         = 16,
    parameter int                 PAGE_BITS      = 12,
    parameter int                 DATA_W         = 64,
    parameter logic [NUM_SRC-1:0] STORE_EOI_MASK = NUM_SRC'(8'h55)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic               acc_valid_i,
    input  logic               acc_write_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    output logic               rd_valid_o,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [NUM_SRC-1:0] notify_o
);
    localparam int PAD_W = DATA_W - $bits(pq_t);

    logic [NUM_SRC-1:0] sel;
    pq_op_e             op;
    pq_t                set_val;
    logic               is_read;
    pq_t                view_w [NUM_SRC];
    pq_t                rd_next;

    pq_decode #(
        .NUM_SRC        (NUM_SRC),
        .ADDR_W         (ADDR_W),
        .PAGE_BITS      (PAGE_BITS),
        .STORE_EOI_MASK (STORE_EOI_MASK)
    ) u_decode (
        .acc_valid_i (acc_valid_i),
        .acc_write_i (acc_write_i),
        .acc_addr_i  (acc_addr_i),
        .sel_o       (sel),
        .op_o        (op),
        .set_val_o   (set_val),
        .is_read_o   (is_read)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        pq_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .trig_i    (trig_i[i]),
            .sel_i     (sel[i]),
            .op_i      (op),
            .set_val_i (set_val),
            .view_o    (view_w[i]),
            .notify_o  (notify_o[i])
        );
    end

    always_comb begin
        rd_next = PQ_IDLE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel[i] && is_read) rd_next = view_w[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= is_read;
            rd_data_o  <= {{PAD_W{1'b0}}, rd_next};
        end
    end

    p_rdvalid_follows_read_r11: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(acc_valid_i && !acc_write_i));

    p_undecoded_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && $past(op) == OP_NONE) |-> rd_data_o == '0);

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[DATA_W-1:2] == '0);

endmodule

// File: tb/pq_source_bank_bench.sv
module pq_source_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC = 8;
    localparam int ADDR_W = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] trig_i = '0;
    logic               acc_valid_i = 1'b0;
    logic               acc_write_i = 1'b0;
    logic [ADDR_W-1:0]  acc_addr_i = '0;
    logic               rd_valid_o;
    logic [63:0]        rd_data_o;
    logic [NUM_SRC-1:0] notify_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        s_rdv;
    logic [63:0] s_rdd;
    logic [7:0]  s_ntf;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pq_source_bank u_pq_source_bank (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig_i),
        .acc_valid_i (acc_valid_i),
        .acc_write_i (acc_write_i),
        .acc_addr_i  (acc_addr_i),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .notify_o    (notify_o)
    );

    function automatic logic [15:0] adr(int src, logic [11:0] ofs);
        return {src[3:0], ofs};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic [7:0] trg, logic v, logic w, logic [15:0] a);
        @(negedge clk);
        trig_i      = trg;
        acc_valid_i = v;
        acc_write_i = w;
        acc_addr_i  = a;
        @(negedge clk);
        s_rdv = rd_valid_o;
        s_rdd = rd_data_o;
        s_ntf = notify_o;
        trig_i      = '0;
        acc_valid_i = 1'b0;
        acc_write_i = 1'b0;
    endtask

    task automatic get_chk(int src, logic [1:0] exp, string tag);
        cyc('0, 1'b1, 1'b0, adr(src, 12'h800));
        chk(tag, s_rdd, {62'b0, exp});
    endtask

    task automatic t_reset();
        chk("R1 rd_valid after reset", {63'b0, rd_valid_o}, 64'h0);
        chk("R1 notify after reset", {56'b0, notify_o}, 64'h0);
        get_chk(0, 2'b00, "R1 src0 state");
        get_chk(7, 2'b00, "R1 src7 state");
    endtask

    task automatic t_first_trigger();
        cyc(8'h01, 1'b0, 1'b0, '0);
        chk("R2 R11 notify next cycle", {56'b0, s_ntf}, 64'h1);
        get_chk(0, 2'b10, "R2 state after trigger");
        chk("R6 R11 rd_valid on read", {63'b0, s_rdv}, 64'h1);
        get_chk(0, 2'b10, "R6 query leaves state");
    endtask

    task automatic t_coalesce();
        cyc(8'h01, 1'b0, 1'b0, '0);
        chk("R3 no notify while pending", {56'b0, s_ntf}, 64'h0);
        get_chk(0, 2'b11, "R3 Q set");
        cyc(8'h01, 1'b0, 1'b0, '0);
        chk("R3 stays quiet at 11", {56'b0, s_ntf}, 64'h0);
        get_chk(0, 2'b11, "R3 stays 11");
    endtask

    task automatic t_load_eoi();
        cyc('0, 1'b1, 1'b0, adr(0, 12'h000));
        chk("R5 eoi returns 11", s_rdd, 64'h3);
        chk("R5 eoi from 11 refires", {56'b0, s_ntf}, 64'h1);
        get_chk(0, 2'b10, "R5 11 to 10");
        cyc('0, 1'b1, 1'b0, adr(0, 12'h000));
        chk("R5 eoi returns 10", s_rdd, 64'h2);
        chk("R5 eoi from 10 quiet", {56'b0, s_ntf}, 64'h0);
        get_chk(0, 2'b00, "R5 10 to 00");
    endtask

    task automatic t_force();
        cyc('0, 1'b1, 1'b0, adr(2, 12'hE00));
        chk("R7 set10 returns 00", s_rdd, 64'h0);
        cyc('0, 1'b1, 1'b0, adr(2, 12'hF00));
        chk("R7 set11 returns 10", s_rdd, 64'h2);
        cyc('0, 1'b1, 1'b0, adr(2, 12'hD00));
        chk("R7 set01 returns 11", s_rdd, 64'h3);
        cyc('0, 1'b1, 1'b0, adr(2, 12'hC00));
        chk("R7 set00 returns 01", s_rdd, 64'h1);
        get_chk(2, 2'b00, "R7 final 00");
    endtask

    task automatic t_off();
        cyc('0, 1'b1, 1'b0, adr(3, 12'hD00));
        cyc(8'h08, 1'b0, 1'b0, '0);
        chk("R4 trigger while off quiet", {56'b0, s_ntf}, 64'h0);
        cyc('0, 1'b1, 1'b0, adr(3, 12'h000));
        chk("R4 eoi returns 01", s_rdd, 64'h1);
        chk("R4 eoi off quiet", {56'b0, s_ntf}, 64'h0);
        get_chk(3, 2'b01, "R4 stays 01");
    endtask

    task automatic t_store_eoi();
        cyc(8'h01, 1'b0, 1'b0, '0);
        cyc('0, 1'b1, 1'b1, adr(0, 12'h400));
        chk("R8 write gives no rd_valid", {63'b0, s_rdv}, 64'h0);
        get_chk(0, 2'b00, "R8 capable source cleared");
        cyc(8'h02, 1'b0, 1'b0, '0);
        chk("R2 src1 notify", {56'b0, s_ntf}, 64'h2);
        cyc('0, 1'b1, 1'b1, adr(1, 12'h400));
        get_chk(1, 2'b10, "R8 incapable source unchanged");
        cyc('0, 1'b1, 1'b1, adr(0, 12'hC00));
        cyc('0, 1'b1, 1'b0, adr(1, 12'hC00));
    endtask

    task automatic t_decode();
        cyc('0, 1'b1, 1'b0, adr(9, 12'h800));
        chk("R9 out-of-range rd_valid", {63'b0, s_rdv}, 64'h1);
        chk("R9 out-of-range data", s_rdd, 64'h0);
        cyc('0, 1'b1, 1'b0, adr(4, 12'hF00));
        cyc('0, 1'b1, 1'b0, adr(4, 12'h100));
        chk("R9 undecoded offset data", s_rdd, 64'h0);
        get_chk(4, 2'b11, "R9 undecoded offset no change");
        cyc('0, 1'b1, 1'b0, adr(5, 12'hE00));
        get_chk(5, 2'b10, "R9 page index src5");
        get_chk(6, 2'b00, "R9 neighbour src6 untouched");
    endtask

    task automatic t_same_cycle();
        cyc(8'h40, 1'b1, 1'b0, adr(6, 12'h000));
        chk("R10 read sees post-trigger", s_rdd, 64'h2);
        chk("R10 trigger notify", {56'b0, s_ntf}, 64'h40);
        get_chk(6, 2'b00, "R10 eoi after trigger");
        cyc(8'h80, 1'b1, 1'b0, adr(7, 12'h800));
        chk("R10 query same cycle", s_rdd, 64'h2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_trigger();
        t_coalesce();
        t_load_eoi();
        t_force();
        t_off();
        t_store_eoi();
        t_decode();
        t_same_cycle();
        finish_run();
    end
endmodule